// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns one machine cycle of a small 8-bit controller core into the pin activity of its external memory bus. Every machine cycle lasts twelve clocks. At the last clock of a cycle the block latches the core's next request. A request is an operation code, a 16-bit address, a write byte and the level of the external-access select pin. The following twelve clocks then drive a shared low-address/data port, a high-address port, an address latch strobe, a program fetch strobe and separate data read and write strobes.

A code fetch cycle fetches two bytes: one at the request address and one at the address after it. Each byte is steered on its own. When the select pin is high, a byte whose address lies at or below the internal boundary (3FFFh by default) comes from internal memory. In that case no fetch strobe appears and nothing is put on the address ports, although the latch strobe keeps its normal timing. Bytes from the bus are returned to the core with a one-clock valid pulse. A data read returns the sampled byte the same way. A data cycle uses only the first latch pulse and never raises the fetch strobe.

The shared port is given as separate output, output-enable and input vectors, so the pad ring builds the three-state driver.

Top module: `xbus_seq`

## Requirements
- R1: A machine cycle is 12 clocks, numbered k=0..11. cyc_take_o is high during k=11. The request is latched at the edge that ends that clock. The op codes are 00 idle, 01 code fetch, 10 data read and 11 data write. In fetch and idle cycles ale_o is high in k=1,2 and in k=7,8.
- R2: In read and write cycles ale_o is high only in k=1,2, and psen_no stays high for the whole cycle.
- R3: For an external fetch byte, psen_no is low in k=4,5 for the byte at the request address and in k=10,11 for the byte at the next address. ad_i is sampled at the edge ending k=5 (or k=11). code_vld_o is high for one clock in the following clock, with code_ext_o=1 and code_data_o equal to the sampled byte.
- R4: The low address byte is driven on ad_o with ad_oe_o=1 in k=1..3, and in k=7..9 for the second fetch byte (the next address). This happens for each external fetch byte and for every data cycle. a_hi_oe_o=1 with the upper address byte for the half-cycle of each external fetch byte (k=0..5 or k=6..11), and for the whole of a data cycle.
- R5: A fetch byte goes to the bus when ea_i=0 or when its address is above 3FFFh. Otherwise it is internal: psen_no stays high, neither address port is enabled in its half-cycle, and code_vld_o still pulses with code_ext_o=0 and code_data_o=00h. The fetch address after FFFFh wraps to 0000h.
- R6: In a read cycle rd_no is low in k=4..10 and the shared port is released. ad_i is sampled at the edge ending k=10. rdata_vld_o is high in k=11 with that byte on rdata_o.
- R7: In a write cycle wr_no is low in k=4..10, and ad_o drives the write byte with ad_oe_o=1 in exactly those clocks.
- R8: An idle cycle drives no fetch, read or write strobe and never enables either address port.
- R9: ad_oe_o is 0 in every clock not named in R4 or R7. At most one of ale_o high, psen_no low, rd_no low and wr_no low holds in any clock.
- R10: While rst_ni is low and right after it rises, ale_o is 0, all three strobes are high, both port enables are 0 and both valid outputs are 0. The first machine cycle after reset is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, one per phase |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_op_i | input | 2 | Operation for the next cycle |
| cyc_addr_i | input | 16 | Code or data address |
| cyc_wdata_i | input | 8 | Byte for a write cycle |
| ea_i | input | 1 | External-access select, high allows internal code |
| cyc_take_o | output | 1 | Request is latched at the end of this clock |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_no | output | 1 | Program fetch strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Shared port output value |
| ad_oe_o | output | 1 | Shared port output enable |
| ad_i | input | 8 | Shared port input value |
| a_hi_o | output | 8 | Upper address byte |
| a_hi_oe_o | output | 1 | Upper address port enable |
| code_data_o | output | 8 | Fetched code byte |
| code_vld_o | output | 1 | Code byte valid pulse |
| code_ext_o | output | 1 | Code byte came from the bus |
| rdata_o | output | 8 | Byte read from data memory |
| rdata_vld_o | output | 1 | Read byte valid pulse |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit data path and an internal boundary of 3FFFh. With these values the full address space can be reached directly. A fetch at 3FFFh with the select pin high splits across the boundary, with the first byte internal and the second external. A fetch at FFFFh checks the wrap of the second byte address. Every pin is compared clock by clock over whole machine cycles for each op code and for both select levels, so the skipped latch pulse and the skipped fetch strobes are checked at their exact clocks.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_FETCH = 2'b01,
    OP_READ  = 2'b10,
    OP_WRITE = 2'b11
  } bus_op_e;

  localparam int unsigned SLOT_W = 4;
  localparam logic [SLOT_W-1:0] S_LAST   = 4'd11;
  localparam logic [SLOT_W-1:0] S_HALF   = 4'd6;
  // first half of the cycle
  localparam logic [SLOT_W-1:0] S_ALE0_B = 4'd1;
  localparam logic [SLOT_W-1:0] S_ALE0_E = 4'd2;
  localparam logic [SLOT_W-1:0] S_ADR0_E = 4'd3;
  localparam logic [SLOT_W-1:0] S_PS0_B  = 4'd4;
  localparam logic [SLOT_W-1:0] S_PS0_E  = 4'd5;
  // second half of the cycle
  localparam logic [SLOT_W-1:0] S_ALE1_B = 4'd7;
  localparam logic [SLOT_W-1:0] S_ALE1_E = 4'd8;
  localparam logic [SLOT_W-1:0] S_ADR1_E = 4'd9;
  localparam logic [SLOT_W-1:0] S_PS1_B  = 4'd10;
  localparam logic [SLOT_W-1:0] S_PS1_E  = 4'd11;
  // data strobe window
  localparam logic [SLOT_W-1:0] S_DS_B   = 4'd4;
  localparam logic [SLOT_W-1:0] S_DS_E   = 4'd10;

  function automatic logic in_rng(input logic [SLOT_W-1:0] s,
                                  input logic [SLOT_W-1:0] lo,
                                  input logic [SLOT_W-1:0] hi);
    return (s >= lo) && (s <= hi);
  endfunction
endpackage

// File: rtl/xbus_seq_timer.sv
module xbus_seq_timer
  import xbus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  logic [SLOT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q == S_LAST) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 4'd1;
  end

  assign slot_o = cnt_q;
  assign last_o = (cnt_q == S_LAST);
endmodule

// File: rtl/xbus_seq_steer.sv
module xbus_seq_steer
  import xbus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h3FFF
) (
  input  bus_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ea_i,
  output logic [ADDR_W-1:0] addr_nxt_o,
  output logic [1:0]        ext_o
);
  localparam logic [ADDR_W-1:0] ONE = 1;

  logic [ADDR_W-1:0] half_addr [2];

  assign addr_nxt_o   = addr_i + ONE;
  assign half_addr[0] = addr_i;
  assign half_addr[1] = addr_nxt_o;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign ext_o[h] = (op_i == OP_FETCH) && (!ea_i || (half_addr[h] > INT_TOP));
  end
endmodule

// File: rtl/xbus_seq_pins.sv
module xbus_seq_pins
  import xbus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  bus_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] addr_nxt_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        ext_i,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   a_hi_o,
  output logic              a_hi_oe_o
);
  logic [1:0] ale_win, adr_win, ps_win;
  logic       is_data, is_rd, is_wr, ds_win, first_half;

  for (genvar h = 0; h < 2; h++) begin : g_win
    localparam logic [SLOT_W-1:0] AB = (h == 0) ? S_ALE0_B : S_ALE1_B;
    localparam logic [SLOT_W-1:0] AE = (h == 0) ? S_ALE0_E : S_ALE1_E;
    localparam logic [SLOT_W-1:0] DE = (h == 0) ? S_ADR0_E : S_ADR1_E;
    localparam logic [SLOT_W-1:0] PB = (h == 0) ? S_PS0_B  : S_PS1_B;
    localparam logic [SLOT_W-1:0] PE = (h == 0) ? S_PS0_E  : S_PS1_E;
    assign ale_win[h] = in_rng(slot_i, AB, AE);
    assign adr_win[h] = in_rng(slot_i, AB, DE);
    assign ps_win[h]  = in_rng(slot_i, PB, PE);
  end

  assign is_data    = op_i[1];
  assign is_rd      = (op_i == OP_READ);
  assign is_wr      = (op_i == OP_WRITE);
  assign ds_win     = in_rng(slot_i, S_DS_B, S_DS_E);
  assign first_half = (slot_i < S_HALF);

  // data cycle drops the second latch pulse
  assign ale_o   = ale_win[0] | (ale_win[1] & ~is_data);
  assign psen_no = ~|(ps_win & ext_i);
  assign rd_no   = ~(is_rd & ds_win);
  assign wr_no   = ~(is_wr & ds_win);

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    if (adr_win[0] && (ext_i[0] || is_data)) begin
      ad_o    = addr_i[DATA_W-1:0];
      ad_oe_o = 1'b1;
    end else if (adr_win[1] && ext_i[1]) begin
      ad_o    = addr_nxt_i[DATA_W-1:0];
      ad_oe_o = 1'b1;
    end else if (is_wr && ds_win) begin
      ad_o    = wdata_i;
      ad_oe_o = 1'b1;
    end
  end

  always_comb begin
    a_hi_oe_o = is_data | (first_half ? ext_i[0] : ext_i[1]);
    a_hi_o    = '0;
    if (a_hi_oe_o)
      a_hi_o = (is_data || first_half) ? addr_i[ADDR_W-1:DATA_W]
                                       : addr_nxt_i[ADDR_W-1:DATA_W];
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h3FFF,
  localparam int unsigned HI_W = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cyc_op_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic [DATA_W-1:0] cyc_wdata_i,
  input  logic              ea_i,
  output logic              cyc_take_o,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic [HI_W-1:0]   a_hi_o,
  output logic              a_hi_oe_o,
  output logic [DATA_W-1:0] code_data_o,
  output logic              code_vld_o,
  output logic              code_ext_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o
);
  logic [SLOT_W-1:0] slot;
  logic              last;
  bus_op_e           op_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [DATA_W-1:0] wdata_q;
  logic              ea_q;
  logic [1:0]        ext_v;
  logic              code_cap, code_hsel;

  xbus_seq_timer u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot),
    .last_o (last)
  );

  xbus_seq_steer #(.ADDR_W(ADDR_W), .INT_TOP(INT_TOP)) u_steer (
    .op_i       (op_q),
    .addr_i     (addr_q),
    .ea_i       (ea_q),
    .addr_nxt_o (addr_nxt),
    .ext_o      (ext_v)
  );

  xbus_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .slot_i     (slot),
    .op_i       (op_q),
    .addr_i     (addr_q),
    .addr_nxt_i (addr_nxt),
    .wdata_i    (wdata_q),
    .ext_i      (ext_v),
    .ale_o      (ale_o),
    .psen_no    (psen_no),
    .rd_no      (rd_no),
    .wr_no      (wr_no),
    .ad_o       (ad_o),
    .ad_oe_o    (ad_oe_o),
    .a_hi_o     (a_hi_o),
    .a_hi_oe_o  (a_hi_oe_o)
  );

  assign cyc_take_o = last;
  assign code_hsel  = (slot == S_PS1_E);
  assign code_cap   = (op_q == OP_FETCH) && ((slot == S_PS0_E) || code_hsel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      ea_q    <= 1'b0;
    end else if (last) begin
      op_q    <= bus_op_e'(cyc_op_i);
      addr_q  <= cyc_addr_i;
      wdata_q <= cyc_wdata_i;
      ea_q    <= ea_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_data_o <= '0;
      code_vld_o  <= 1'b0;
      code_ext_o  <= 1'b0;
      rdata_o     <= '0;
      rdata_vld_o <= 1'b0;
    end else begin
      code_vld_o  <= code_cap;
      rdata_vld_o <= 1'b0;
      if (code_cap) begin
        code_ext_o  <= ext_v[code_hsel];
        code_data_o <= ext_v[code_hsel] ? ad_i : '0;
      end
      if ((op_q == OP_READ) && (slot == S_DS_E)) begin
        rdata_o     <= ad_i;
        rdata_vld_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ale_o,
  input logic              psen_no,
  input logic              rd_no,
  input logic              wr_no,
  input logic [DATA_W-1:0] ad_o,
  input logic              ad_oe_o,
  input logic              a_hi_oe_o,
  input logic              code_vld_o
);
  AST_ALE_TWO_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |=> ale_o ##1 !ale_o); // R1

  AST_NO_FETCH_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> psen_no); // R2

  AST_FETCH_PORT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> !ad_oe_o); // R3

  AST_CODE_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_vld_o |=> !code_vld_o); // R3

  AST_FETCH_HI_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> a_hi_oe_o); // R4

  AST_READ_PORT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o); // R6

  AST_WRITE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> ad_oe_o); // R7

  AST_WDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no && $past(!wr_no)) |-> $stable(ad_o)); // R7

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ale_o, !psen_no, !rd_no, !wr_no}) <= 1); // R9
endmodule

bind xbus_seq xbus_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ale_o      (ale_o),
  .psen_no    (psen_no),
  .rd_no      (rd_no),
  .wr_no      (wr_no),
  .ad_o       (ad_o),
  .ad_oe_o    (ad_oe_o),
  .a_hi_oe_o  (a_hi_oe_o),
  .code_vld_o (code_vld_o)
);

// File: tb/xbus_seq_tb_top.sv
`timescale 1ns/1ps
module xbus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cyc_op = 2'b00;
  logic [15:0] cyc_addr = '0;
  logic [7:0]  cyc_wdata = '0;
  logic        ea = 1'b0;
  logic [7:0]  ad_in = 8'h5A;
  logic        cyc_take, ale, psen_n, rd_n, wr_n, ad_oe, a_hi_oe;
  logic        code_vld, code_ext, rdata_vld;
  logic [7:0]  ad_out, a_hi, code_data, rdata;
  int          checks = 0;
  int          failures = 0;

  always #2 clk = ~clk;

  xbus_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_op_i(cyc_op), .cyc_addr_i(cyc_addr),
    .cyc_wdata_i(cyc_wdata), .ea_i(ea), .cyc_take_o(cyc_take), .ale_o(ale),
    .psen_no(psen_n), .rd_no(rd_n), .wr_no(wr_n), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .ad_i(ad_in), .a_hi_o(a_hi), .a_hi_oe_o(a_hi_oe), .code_data_o(code_data),
    .code_vld_o(code_vld), .code_ext_o(code_ext), .rdata_o(rdata),
    .rdata_vld_o(rdata_vld)
  );

  task automatic chk(input string req, input string what, input int k,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s k=%0d act=%0h exp=%0h", req, what, k, act, exp);
    end
  endtask

  function automatic logic rng(input int k, input int lo, input int hi);
    return (k >= lo) && (k <= hi);
  endfunction

  // one machine cycle, every pin compared per clock
  task automatic run_cycle(input string tag, input logic [1:0] op,
                           input logic [15:0] addr, input logic [7:0] wd,
                           input logic e, input logic [7:0] b0, input logic [7:0] b1);
    logic [15:0] a1 = addr + 16'd1;
    logic data = op[1];
    logic fet = (op == 2'b01);
    logic e0 = fet && (!e || addr > 16'h3FFF);
    logic e1 = fet && (!e || a1 > 16'h3FFF);
    cyc_op = op; cyc_addr = addr; cyc_wdata = wd; ea = e;
    do @(negedge clk); while (!cyc_take);
    for (int k = 0; k < 12; k++) begin
      logic x_ale, x_ps, x_oe, x_hoe;
      logic [7:0] x_ad, x_hi;
      @(negedge clk);
      x_ale = rng(k, 1, 2) || (!data && rng(k, 7, 8));
      x_ps  = !((e0 && rng(k, 4, 5)) || (e1 && rng(k, 10, 11)));
      x_oe = 1'b0; x_ad = 8'h00;
      if (rng(k, 1, 3) && (e0 || data)) begin x_oe = 1'b1; x_ad = addr[7:0]; end
      else if (rng(k, 7, 9) && e1) begin x_oe = 1'b1; x_ad = a1[7:0]; end
      else if (op == 2'b11 && rng(k, 4, 10)) begin x_oe = 1'b1; x_ad = wd; end
      x_hoe = data || (k < 6 ? e0 : e1);
      x_hi  = (data || k < 6) ? addr[15:8] : a1[15:8];
      chk(rng(k, 7, 8) && data ? "R2" : "R1", {tag, " ale"}, k, 32'(ale), 32'(x_ale));
      chk(data ? "R2" : tag, {tag, " psen_n"}, k, 32'(psen_n), 32'(x_ps));
      chk("R6", {tag, " rd_n"}, k, 32'(rd_n), 32'(!(op == 2'b10 && rng(k, 4, 10))));
      chk("R7", {tag, " wr_n"}, k, 32'(wr_n), 32'(!(op == 2'b11 && rng(k, 4, 10))));
      chk(x_oe ? "R4" : "R9", {tag, " ad_oe"}, k, 32'(ad_oe), 32'(x_oe));
      if (x_oe) chk(op == 2'b11 && k > 3 ? "R7" : "R4", {tag, " ad_o"}, k, 32'(ad_out), 32'(x_ad));
      chk(op == 2'b00 ? "R8" : "R4", {tag, " a_hi_oe"}, k, 32'(a_hi_oe), 32'(x_hoe));
      if (x_hoe) chk("R4", {tag, " a_hi"}, k, 32'(a_hi), 32'(x_hi));
      chk("R1", {tag, " take"}, k, 32'(cyc_take), 32'(k == 11));
      if (k > 0) chk(tag, {tag, " code_vld"}, k, 32'(code_vld), 32'(fet && k == 6));
      if (fet && k == 6) begin
        chk(tag, {tag, " code_ext0"}, k, 32'(code_ext), 32'(e0));
        chk(tag, {tag, " code_data0"}, k, 32'(code_data), 32'(e0 ? b0 : 8'h00));
      end
      chk("R6", {tag, " rdata_vld"}, k, 32'(rdata_vld), 32'(op == 2'b10 && k == 11));
      if (op == 2'b10 && k == 11) chk("R6", {tag, " rdata"}, k, 32'(rdata), 32'(b0));
      // memory model drives the port for the next edge
      if (fet && rng(k, 4, 5)) ad_in = b0;
      else if (fet && rng(k, 10, 11)) ad_in = b1;
      else if (op == 2'b10 && rng(k, 4, 10)) ad_in = b0;
      else ad_in = 8'h5A;
    end
    @(negedge clk);
    chk(tag, {tag, " code_vld1"}, 0, 32'(code_vld), 32'(fet));
    if (fet) begin
      chk(tag, {tag, " code_ext1"}, 0, 32'(code_ext), 32'(e1));
      chk(tag, {tag, " code_data1"}, 0, 32'(code_data), 32'(e1 ? b1 : 8'h00));
    end
  endtask

  task automatic t_reset();
    chk("R10", "reset ale", 0, 32'(ale), 32'd0);
    chk("R10", "reset strobes", 0, 32'({psen_n, rd_n, wr_n}), 32'h7);
    chk("R10", "reset oe", 0, 32'({ad_oe, a_hi_oe}), 32'h0);
    chk("R10", "reset vld", 0, 32'({code_vld, rdata_vld}), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "post reset strobes", 0, 32'({psen_n, rd_n, wr_n}), 32'h7);
    chk("R10", "post reset oe", 0, 32'({ad_oe, a_hi_oe}), 32'h0);
  endtask

  task automatic t_fetch_ext();  run_cycle("R3", 2'b01, 16'h0123, 8'h00, 1'b0, 8'hC3, 8'h3C); endtask
  task automatic t_fetch_int();  run_cycle("R5", 2'b01, 16'h1234, 8'h00, 1'b1, 8'h11, 8'h22); endtask
  task automatic t_fetch_edge(); run_cycle("R5", 2'b01, 16'h3FFF, 8'h00, 1'b1, 8'h77, 8'h88); endtask
  task automatic t_fetch_high(); run_cycle("R5", 2'b01, 16'h8000, 8'h00, 1'b1, 8'h9A, 8'hAB); endtask
  task automatic t_fetch_wrap(); run_cycle("R5", 2'b01, 16'hFFFF, 8'h00, 1'b0, 8'hE1, 8'h1E); endtask
  task automatic t_read();       run_cycle("R6", 2'b10, 16'hBEEF, 8'h00, 1'b1, 8'h6D, 8'h00); endtask
  task automatic t_write();      run_cycle("R7", 2'b11, 16'h4A55, 8'hD2, 1'b0, 8'h00, 8'h00); endtask
  task automatic t_idle();       run_cycle("R8", 2'b00, 16'h7FFF, 8'hFF, 1'b0, 8'h00, 8'h00); endtask

  initial begin
    #(4 * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_fetch_ext();
    t_fetch_int();
    t_fetch_edge();
    t_fetch_high();
    t_fetch_wrap();
    t_read();
    t_write();
    t_idle();
    t_fetch_ext();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule